// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the transfer-side engine of a single DMA channel. It holds the channel's current 16-bit memory address and its 16-bit remaining transfer count. It joins the address with an 8-bit page value into a 24-bit physical address, which reaches 16 MB.

The channel has two sizes:

- **Byte channel:** pages are 64K long.
- **Word channel:** the address is shifted left by one and page bit 0 is dropped, so pages are 128K long.

The address never carries into the page, so a run of transfers wraps inside its page.

The register interface supplies the base address, the base count, the page and the mode bits. Those mode bits are word size, auto-initialize and step direction. A one-cycle arm strobe copies the base values into the current registers and unmasks the channel. The count is programmed as the number of transfers minus one.

Transfers run in single mode. An unmasked request produces an acknowledge. The acknowledge is held until the bus side strobes transfer-done. Each transfer then steps the address and decrements the count.

The transfer that takes the count from 0x0000 to 0xFFFF raises terminal count for one cycle. At that point the channel does one of two things:

- **Auto-initialize off:** the channel masks itself.
- **Auto-initialize on:** the channel reloads its current address and count from the base values.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset masked_o is 1, dack_o is 0, tc_o is 0, cur_cnt_o is 0x0000 and the address register is 0x0000.
- R2: An arm_i pulse loads the current address from base_addr_i and the count from base_cnt_i, clears the mask, drops dack_o and suppresses tc_o, all visible the next cycle; arm_i wins over a completion in the same cycle.
- R3: With word_i=0 the physical address is {page_i[7:0], address[15:0]}.
- R4: With word_i=1 the physical address is {page_i[7:1], address[15:0], 1'b0}; page_i bit 0 has no effect.
- R5: Each completion decrements the count by one and steps the address by +1 when incr_i=1 or -1 when incr_i=0. A completion is xfer_done_i high while dack_o is high. Both count and address wrap modulo 2^16, and the page-derived bits do not change.
- R6: tc_o is high for exactly one cycle, the cycle after the completion made at count 0x0000, so a programmed count N yields N+1 transfers.
- R7: With auto_i=0, that terminal completion sets masked_o to 1 and leaves the count at 0xFFFF, with the address stepped as usual.
- R8: With auto_i=1, that terminal completion reloads address and count from the base inputs and masked_o stays 0.
- R9: When unmasked and idle, dreq_i high makes dack_o high the next cycle. dack_o stays high until the cycle after xfer_done_i, then is low for at least one cycle.
- R10: While masked, dreq_i is ignored and dack_o stays 0. While dack_o is 0, xfer_done_i changes neither the count nor the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Load current registers from base values and unmask |
| base_addr_i | input | 16 | Base address |
| base_cnt_i | input | 16 | Base count (transfers minus one) |
| page_i | input | 8 | Page value |
| word_i | input | 1 | 1 = word channel, 0 = byte channel |
| auto_i | input | 1 | Auto-initialize at terminal count |
| incr_i | input | 1 | 1 = address increments, 0 = decrements |
| dreq_i | input | 1 | Transfer request |
| xfer_done_i | input | 1 | Current transfer finished |
| phys_addr_o | output | 24 | Physical address |
| cur_cnt_o | output | 16 | Current remaining count |
| dack_o | output | 1 | Acknowledge; transfer in progress |
| tc_o | output | 1 | Terminal count pulse |
| masked_o | output | 1 | Channel mask state |

## Verification
Terminal count and auto-initialize reload fall in the same cycle. The completion that ends the run must both raise tc_o and replace the stepped address and count with the base values.

A second collision is an arm pulse landing on a completion. Here arm must win, and the stepped values and the terminal pulse must both be discarded.

Directed sequences drive each collision deliberately, and a long random phase drives them again at random. On every cycle a behavioural model in the bench judges the address, count, acknowledge, mask and terminal pulse.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  // Channel operating mode as seen by the sequencer.
  typedef struct packed {
    logic auto_init;  // reload from base values at terminal count
    logic incr;       // 1 = address counts up, 0 = down
    logic word;       // 1 = 16-bit channel, 0 = 8-bit channel
  } chan_mode_t;
endpackage

// File: rtl/dma_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dma_cnt_unit.sv
// Remaining-count register with terminal detection.
module dma_cnt_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             step_i,
  input  logic             auto_i,
  input  logic [CNT_W-1:0] base_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             reload;

  assign last_o = (cnt_q == '0);
  assign reload = step_i & last_o & auto_i;
  assign cnt_en = arm_i | step_i;

  always_comb begin
    cnt_d = cnt_q;
    if (arm_i || reload) cnt_d = base_i;
    else if (step_i)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R5: ordinary completion decrements by one, wrapping 0 -> all ones.
  a_r5_cnt_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !arm_i && !(last_o && auto_i)) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
  // R8: terminal completion under auto-initialize reloads the base count.
  a_r8_cnt_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !arm_i && last_o && auto_i) |=> cnt_q == $past(base_i));
  // R2: arm loads the base count.
  a_r2_cnt_arm: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> cnt_q == $past(base_i));
  // R10: no completion, no change.
  a_r10_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_i && !step_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dma_addr_unit.sv
// Current-address register and physical address composition.
module dma_addr_unit
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  localparam int PHYS_W = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              step_i,
  input  logic              last_i,
  input  chan_mode_t        mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [PHYS_W-1:0] phys_o
);
  logic [ADDR_W-1:0] addr_q, addr_d, addr_nxt;
  logic              addr_en;
  logic              reload;

  assign reload  = step_i & last_i & mode_i.auto_init;
  assign addr_en = arm_i | step_i;
  // Wrap inside the 16-bit field; never carries into the page.
  assign addr_nxt = mode_i.incr ? addr_q + 1'b1 : addr_q - 1'b1;

  always_comb begin
    addr_d = addr_q;
    if (arm_i || reload) addr_d = base_i;
    else if (step_i)     addr_d = addr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  // Word channels drop page bit 0 and address 16-bit units.
  assign phys_o = mode_i.word ? {page_i[PAGE_W-1:1], addr_q, 1'b0}
                              : {page_i, addr_q};

  // R5: up-stepping wraps modulo 2^ADDR_W.
  a_r5_addr_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !arm_i && !reload && mode_i.incr) |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));
  // R5: down-stepping wraps modulo 2^ADDR_W.
  a_r5_addr_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !arm_i && !reload && !mode_i.incr) |=> addr_q == ADDR_W'($past(addr_q) - 1'b1));
  // R8: terminal completion under auto-initialize reloads the base address.
  a_r8_addr_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !arm_i && reload) |=> addr_q == $past(base_i));
endmodule

// File: rtl/dma_chan_ctrl.sv
// Request/acknowledge, mask and terminal-count control.
module dma_chan_ctrl
  import dma_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_i,
  input  logic       dreq_i,
  input  logic       done_i,
  input  logic       last_i,
  input  chan_mode_t mode_i,
  output logic       busy_o,
  output logic       masked_o,
  output logic       tc_o,
  output logic       step_o
);
  logic busy_q, busy_d;
  logic mask_q, mask_d;
  logic tc_q, tc_d;
  logic step;

  assign step = busy_q & done_i;

  always_comb begin
    busy_d = busy_q;
    mask_d = mask_q;
    tc_d   = 1'b0;
    if (arm_i) begin
      busy_d = 1'b0;
      mask_d = 1'b0;
    end else if (busy_q) begin
      if (done_i) begin
        busy_d = 1'b0;
        tc_d   = last_i;
        if (last_i && !mode_i.auto_init) mask_d = 1'b1;
      end
    end else begin
      busy_d = dreq_i & ~mask_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mask_q <= 1'b1;
      tc_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      mask_q <= mask_d;
      tc_q   <= tc_d;
    end
  end

  assign busy_o   = busy_q;
  assign masked_o = mask_q;
  assign tc_o     = tc_q;
  assign step_o   = step;

  // R10: a masked channel never has an acknowledge out.
  a_r10_mask_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !busy_q);
  // R6: terminal count is a single-cycle pulse.
  a_r6_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |=> !tc_q);
  // R7: terminal completion without auto-initialize masks the channel.
  a_r7_mask_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_i && !mode_i.auto_init && !arm_i) |=> (mask_q && tc_q));
  // R8: terminal completion with auto-initialize keeps the channel open.
  a_r8_stay_open: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_i && mode_i.auto_init && !arm_i) |=> (!mask_q && tc_q));
  // R9: idle, unmasked request is acknowledged next cycle.
  a_r9_ack_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !mask_q && dreq_i && !arm_i) |=> busy_q);
  // R9: acknowledge drops after a completion.
  a_r9_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !busy_q);
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8,
  localparam int PHYS_W = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  base_cnt_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              word_i,
  input  logic              auto_i,
  input  logic              incr_i,
  input  logic              dreq_i,
  input  logic              xfer_done_i,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic [CNT_W-1:0]  cur_cnt_o,
  output logic              dack_o,
  output logic              tc_o,
  output logic              masked_o
);
  chan_mode_t mode;
  logic       rst_sync_n;
  logic       step;
  logic       last;

  assign mode = '{auto_init: auto_i, incr: incr_i, word: word_i};

  dma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dma_chan_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .arm_i    (arm_i),
    .dreq_i   (dreq_i),
    .done_i   (xfer_done_i),
    .last_i   (last),
    .mode_i   (mode),
    .busy_o   (dack_o),
    .masked_o (masked_o),
    .tc_o     (tc_o),
    .step_o   (step)
  );

  dma_cnt_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .arm_i  (arm_i),
    .step_i (step),
    .auto_i (auto_i),
    .base_i (base_cnt_i),
    .cnt_o  (cur_cnt_o),
    .last_o (last)
  );

  dma_addr_unit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .arm_i  (arm_i),
    .step_i (step),
    .last_i (last),
    .mode_i (mode),
    .base_i (base_addr_i),
    .page_i (page_i),
    .phys_o (phys_addr_o)
  );
endmodule

// File: tb/dma_xfer_engine_test.sv
module dma_xfer_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        arm_i, word_i, auto_i, incr_i, dreq_i, xfer_done_i;
  logic [15:0] base_addr_i, base_cnt_i;
  logic [7:0]  page_i;
  logic [23:0] phys_addr_o;
  logic [15:0] cur_cnt_o;
  logic        dack_o, tc_o, masked_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_en   = 1'b0;

  // behavioural reference state
  int m_addr, m_cnt;
  bit m_mask, m_busy, m_tc;

  always #4 clk = ~clk;  // 125 MHz

  dma_xfer_engine uut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .base_addr_i(base_addr_i),
    .base_cnt_i(base_cnt_i), .page_i(page_i), .word_i(word_i), .auto_i(auto_i),
    .incr_i(incr_i), .dreq_i(dreq_i), .xfer_done_i(xfer_done_i),
    .phys_addr_o(phys_addr_o), .cur_cnt_o(cur_cnt_o), .dack_o(dack_o),
    .tc_o(tc_o), .masked_o(masked_o)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic longint model_phys();
    if (word_i) return (longint'(page_i >> 1) << 17) + (longint'(m_addr) * 2);
    return (longint'(page_i) << 16) + longint'(m_addr);
  endfunction

  // Reference model: advances on each rising edge from the sampled inputs.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_cnt = 0; m_mask = 1; m_busy = 0; m_tc = 0;
    end else begin
      automatic bit stp = m_busy && xfer_done_i;
      automatic bit at_end = (m_cnt == 0);
      if (arm_i) begin
        m_addr = base_addr_i; m_cnt = base_cnt_i; m_mask = 0; m_busy = 0; m_tc = 0;
      end else begin
        m_tc = stp && at_end;
        if (stp) begin
          m_busy = 0;
          if (at_end && auto_i) begin
            m_addr = base_addr_i; m_cnt = base_cnt_i;
          end else begin
            m_addr = (m_addr + (incr_i ? 1 : 65535)) % 65536;
            m_cnt  = (m_cnt + 65535) % 65536;
            if (at_end) m_mask = 1;
          end
        end else if (!m_busy && dreq_i && !m_mask) begin
          m_busy = 1;
        end
      end
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (cmp_en) begin
      check(word_i ? "R4" : "R3", "model phys", phys_addr_o, model_phys());
      check("R5", "model count", cur_cnt_o, m_cnt);
      check("R9", "model dack", dack_o, m_busy);
      check("R6", "model tc", tc_o, m_tc);
      check("R7", "model mask", masked_o, m_mask);
    end
  end

  task automatic arm_chan(input logic [15:0] a, input logic [15:0] c);
    base_addr_i = a; base_cnt_i = c; arm_i = 1'b1;
    @(negedge clk);
    arm_i = 1'b0;
  endtask

  // One granted transfer; returns at the negedge where its effect is visible.
  task automatic xfer();
    dreq_i = 1'b1;
    for (int i = 0; i < 20 && !dack_o; i++) @(negedge clk);
    xfer_done_i = 1'b1;
    dreq_i = 1'b0;
    @(negedge clk);
    xfer_done_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; arm_i = 0; word_i = 0; auto_i = 0; incr_i = 1;
    dreq_i = 0; xfer_done_i = 0; base_addr_i = 0; base_cnt_i = 0; page_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;

    // R1 reset state
    check("R1", "count", cur_cnt_o, 0);
    check("R1", "mask", masked_o, 1);
    check("R1", "dack", dack_o, 0);
    check("R1", "tc", tc_o, 0);
    check("R1", "phys", phys_addr_o, 0);

    // R3 byte channel, 3 transfers from 0xFFFE in page 0x12
    page_i = 8'h12;
    arm_chan(16'hFFFE, 16'd2);
    check("R2", "mask after arm", masked_o, 0);
    check("R2", "count after arm", cur_cnt_o, 2);
    check("R3", "byte phys", phys_addr_o, 24'h12FFFE);
    xfer();
    check("R5", "count step", cur_cnt_o, 1);
    check("R5", "addr step", phys_addr_o, 24'h12FFFF);
    xfer();
    check("R5", "wrap without page carry", phys_addr_o, 24'h120000);
    check("R6", "no tc before end", tc_o, 0);
    xfer();
    check("R6", "tc pulse", tc_o, 1);
    check("R7", "masked at end", masked_o, 1);
    check("R7", "count all ones", cur_cnt_o, 16'hFFFF);
    check("R7", "addr stepped", phys_addr_o, 24'h120001);
    @(negedge clk);
    check("R6", "tc one cycle", tc_o, 0);

    // R10 masked channel ignores request and done
    dreq_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R10", "no dack while masked", dack_o, 0);
    end
    xfer_done_i = 1'b1;
    @(negedge clk);
    xfer_done_i = 1'b0; dreq_i = 1'b0;
    @(negedge clk);
    check("R10", "count held", cur_cnt_o, 16'hFFFF);
    check("R10", "addr held", phys_addr_o, 24'h120001);

    // R4 word channel
    word_i = 1'b1; page_i = 8'h35;
    arm_chan(16'h1234, 16'd0);
    check("R4", "word phys", phys_addr_o, 24'h342468);
    page_i = 8'h34;
    #1 check("R4", "page bit0 ignored", phys_addr_o, 24'h342468);

    // R8 auto-initialize with decrement, byte page 0
    word_i = 1'b0; page_i = 8'h00; auto_i = 1'b1; incr_i = 1'b0;
    arm_chan(16'h0100, 16'd1);
    xfer();
    check("R5", "decrement addr", phys_addr_o, 24'h0000FF);
    check("R5", "count 0", cur_cnt_o, 0);
    xfer();
    check("R6", "tc on auto", tc_o, 1);
    check("R8", "addr reloaded", phys_addr_o, 24'h000100);
    check("R8", "count reloaded", cur_cnt_o, 1);
    check("R8", "stays unmasked", masked_o, 0);

    // R9 acknowledge timing with request held
    dreq_i = 1'b1;
    @(negedge clk);
    check("R9", "dack rises", dack_o, 1);
    xfer_done_i = 1'b1;
    @(negedge clk);
    xfer_done_i = 1'b0;
    check("R9", "dack gap", dack_o, 0);
    @(negedge clk);
    check("R9", "dack again", dack_o, 1);

    // R2 arm collides with a completion
    arm_i = 1'b1; xfer_done_i = 1'b1; dreq_i = 1'b0;
    base_addr_i = 16'h4000; base_cnt_i = 16'd5;
    @(negedge clk);
    arm_i = 1'b0; xfer_done_i = 1'b0;
    check("R2", "arm wins addr", phys_addr_o, 24'h004000);
    check("R2", "arm wins count", cur_cnt_o, 5);
    check("R2", "no tc", tc_o, 0);
    check("R2", "dack dropped", dack_o, 0);

    // Random phase judged by the model
    for (int i = 0; i < 4000; i++) begin
      dreq_i      = ($urandom % 4) != 0;
      xfer_done_i = ($urandom % 3) == 0;
      arm_i       = ($urandom % 60) == 0;
      auto_i      = ($urandom % 2) == 0;
      incr_i      = ($urandom % 2) == 0;
      word_i      = ($urandom % 2) == 0;
      page_i      = 8'($urandom);
      base_addr_i = ($urandom % 2) ? 16'hFFFD : 16'($urandom);
      base_cnt_i  = 16'($urandom % 4);
      @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule